// File: doc/BRIEF.md
# Eight-Line Cascadable Interrupt Controller

This block collects eight edge-triggered interrupt requests, ranks them by fixed priority, and presents one interrupt output to a processor. Software sees two byte-wide ports. The port selected by `bus_addr = 0` is the command port, and the port selected by `bus_addr = 1` is the data port. A four-byte initialization sequence sets three things: the vector base, the cascade wiring, and whether in-service bits are skipped (auto end-of-interrupt). After initialization, command bytes perform two tasks. They retire a specific in-service level, and they choose which of the request register or the in-service register the command port reads back. The data port reads and writes the mask.

An acknowledge is a one-cycle strobe. On that strobe the controller registers an 8-bit vector and raises `vec_valid`. It also moves the winning request into the in-service register. The vector is the base with its low three bits replaced by the level number. If the strobe finds no request that can be presented, the controller returns the level-7 vector and changes no state.

Several controllers can be chained. A master knows which of its inputs carry a slave, and when one of those inputs wins it drives the level number on the cascade lines instead of a vector. A slave answers a strobe only when the cascade lines equal its own identity.

The command decoder is a five-state machine:
- ST_UNINIT is the state after reset.
- ST_GET_BASE, ST_GET_CASC and ST_GET_MODE each take one data-port write.
- ST_RUN is normal operation.

The transitions are:
- A command byte 0x11 moves the machine from any state to ST_GET_BASE.
- Each data write advances ST_GET_BASE to ST_GET_CASC, then ST_GET_CASC to ST_GET_MODE, then ST_GET_MODE to ST_RUN.
- ST_RUN stays in ST_RUN until the next 0x11.

Top module: `pic_core`

## Requirements
- R1: After reset, `irq_out` and `vec_valid` are low and a command-port read returns 0x00.
- R2: A command byte of exactly 0x11 starts initialization, and the next three data writes are taken as the base, the cascade word and the mode word. After the third of them, the mask reads 0xFF and command-port reads select the request register.
- R3: Priority is fixed with input 0 highest. `irq_out` is high only when some unmasked request bit exists and no in-service bit is set at the winning level or at any lower-numbered level.
- R4: On an acknowledge strobe with a presentable request, the next cycle shows `vec_valid` = 1 and `vec_out` = {base[7:3], level}. The request bit of that level is cleared and its in-service bit is set.
- R5: On an acknowledge strobe with nothing presentable, the next cycle shows `vec_valid` = 1 and `vec_out` = {base[7:3], 3'b111}, and the in-service register is unchanged.
- R6: A command byte 0x60+n (n = 0..7) clears in-service bit n and no other bit.
- R7: Command byte 0x0A selects the request register and 0x0B selects the in-service register for command-port reads. The selection holds across later commands until it is changed.
- R8: A data-port write in ST_RUN loads the mask, and data-port reads return the mask. A masked input (mask bit = 1) never raises `irq_out`.
- R9: When bit 1 of the mode word is 1, an acknowledge clears the request bit but leaves the in-service register unchanged.
- R10: A request bit is set only on a rising edge of its input. An input held high after its acknowledge does not set the bit again.
- R11: A master (`slave_mode` = 0) whose winning level has its bit set in the cascade word responds to an acknowledge with `casc_drive` = 1, `casc_out` = level and `vec_valid` = 0. A slave (`slave_mode` = 1) responds to a strobe only when `casc_in` equals cascade word bits [2:0]. Otherwise it leaves `vec_valid` low and the request register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = command port, 1 = data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port (combinational) |
| slave_mode | input | 1 | 1 = act as slave, 0 = act as master |
| casc_in | input | 3 | Cascade identity presented by the master |
| req_in | input | 8 | Interrupt request inputs |
| irq_out | output | 1 | Interrupt request to the processor |
| ack_stb | input | 1 | One-cycle acknowledge strobe |
| vec_out | output | 8 | Registered vector |
| vec_valid | output | 1 | Vector from this controller is valid |
| casc_out | output | 3 | Level handed to a slave |
| casc_drive | output | 1 | Cascade lines carry a slave selection |

## Verification
Register writes and request edges take effect at the first clock edge after they are driven. Command-port reads and `irq_out` therefore settle within that same cycle. The vector, `vec_valid` and the cascade outputs are registered on the edge that samples `ack_stb`, and they hold until the next strobe. Every stimulus in the bench is applied on a falling edge and removed on the next falling edge. The expected item is queued only after that second falling edge, and the monitor samples it 1 ns later, when one rising edge has passed and the outputs are stable.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int unsigned BUS_W  = 8;
    localparam int unsigned NUM_IN = 8;

    typedef enum logic [2:0] {
        ST_UNINIT,
        ST_GET_BASE,
        ST_GET_CASC,
        ST_GET_MODE,
        ST_RUN
    } init_state_t;

    localparam logic [7:0] CMD_INIT    = 8'h11;
    localparam logic [7:0] CMD_SEL_REQ = 8'h0A;
    localparam logic [7:0] CMD_SEL_SVC = 8'h0B;
    localparam logic [4:0] CMD_EOI_TOP = 5'b01100;
endpackage

// File: rtl/pic_prio_resolve.sv
module pic_prio_resolve #(
    parameter int unsigned N  = 8,
    parameter int unsigned LW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    input  logic [N-1:0]  insvc,
    output logic          hit,
    output logic [LW-1:0] level
);
    logic found;
    logic blocked;

    always_comb begin
        found = 1'b0;
        level = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) begin
                found = 1'b1;
                level = LW'(i);
            end
        end
        blocked = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (insvc[i] && (LW'(i) <= level)) blocked = 1'b1;
        end
        hit = found && !blocked;
    end
endmodule

// File: rtl/pic_ctrl_fsm.sv
module pic_ctrl_fsm
    import pic_pkg::*;
#(
    parameter int unsigned DW = BUS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          addr,
    input  logic [DW-1:0] wdata,
    output init_state_t   state,
    output logic [DW-1:0] base_q,
    output logic [DW-1:0] casc_q,
    output logic          aeoi_q,
    output logic          sel_svc_q,
    output logic          init_go,
    output logic          init_fin,
    output logic          mask_wr,
    output logic          eoi_go,
    output logic [2:0]    eoi_lvl
);
    init_state_t nxt;
    logic cmd_wr, dat_wr;

    assign cmd_wr  = wr_en && !addr;
    assign dat_wr  = wr_en && addr;
    assign eoi_lvl = wdata[2:0];

    always_comb begin
        nxt      = state;
        init_go  = cmd_wr && (wdata == CMD_INIT);
        init_fin = 1'b0;
        mask_wr  = 1'b0;
        eoi_go   = 1'b0;
        unique case (state)
            ST_UNINIT:   ;
            ST_GET_BASE: if (dat_wr) nxt = ST_GET_CASC;
            ST_GET_CASC: if (dat_wr) nxt = ST_GET_MODE;
            ST_GET_MODE: if (dat_wr) begin
                nxt      = ST_RUN;
                init_fin = 1'b1;
            end
            ST_RUN: begin
                mask_wr = dat_wr;
                eoi_go  = cmd_wr && (wdata[7:3] == CMD_EOI_TOP);
            end
            default: nxt = ST_UNINIT;
        endcase
        if (init_go) nxt = ST_GET_BASE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_UNINIT;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q    <= '0;
            casc_q    <= '0;
            aeoi_q    <= 1'b0;
            sel_svc_q <= 1'b0;
        end else begin
            if (state == ST_GET_BASE && dat_wr) base_q <= wdata;
            if (state == ST_GET_CASC && dat_wr) casc_q <= wdata;
            if (state == ST_GET_MODE && dat_wr) aeoi_q <= wdata[1];
            if (init_fin) sel_svc_q <= 1'b0;
            else if (state == ST_RUN && cmd_wr) begin
                if (wdata == CMD_SEL_REQ) sel_svc_q <= 1'b0;
                if (wdata == CMD_SEL_SVC) sel_svc_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pic_core.sv
module pic_core
    import pic_pkg::*;
#(
    parameter int unsigned DW = BUS_W,
    parameter int unsigned NI = NUM_IN,
    localparam int unsigned LW = $clog2(NI)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic          slave_mode,
    input  logic [LW-1:0] casc_in,
    input  logic [NI-1:0] req_in,
    output logic          irq_out,
    input  logic          ack_stb,
    output logic [DW-1:0] vec_out,
    output logic          vec_valid,
    output logic [LW-1:0] casc_out,
    output logic          casc_drive
);
    init_state_t   state;
    logic [DW-1:0] base_q, casc_q;
    logic          aeoi_q, sel_svc_q, init_go, init_fin, mask_wr, eoi_go;
    logic [2:0]    eoi_lvl;
    logic [NI-1:0] irr, isr, imr, req_q, rise, win_oh, eoi_oh;
    logic          hit, run, my_turn, responding, serve, to_slave;
    logic [LW-1:0] win;

    pic_ctrl_fsm #(.DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .state(state), .base_q(base_q), .casc_q(casc_q),
        .aeoi_q(aeoi_q), .sel_svc_q(sel_svc_q), .init_go(init_go),
        .init_fin(init_fin), .mask_wr(mask_wr), .eoi_go(eoi_go),
        .eoi_lvl(eoi_lvl)
    );

    pic_prio_resolve #(.N(NI), .LW(LW)) u_prio (
        .pend(irr & ~imr), .insvc(isr), .hit(hit), .level(win)
    );

    assign run        = (state == ST_RUN);
    assign rise       = req_in & ~req_q;
    assign win_oh     = NI'(1) << win;
    assign eoi_oh     = eoi_go ? (NI'(1) << eoi_lvl) : '0;
    assign my_turn    = slave_mode ? (casc_in == casc_q[LW-1:0]) : 1'b1;
    assign responding = ack_stb && run && my_turn;
    assign serve      = responding && hit;
    assign to_slave   = !slave_mode && casc_q[win];
    assign irq_out    = run && hit;
    assign bus_rdata  = bus_addr ? DW'(imr) : (sel_svc_q ? DW'(isr) : DW'(irr));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
            irr   <= '0;
            isr   <= '0;
            imr   <= '1;
        end else begin
            req_q <= req_in;
            irr   <= (init_go ? '0 : (irr & ~(serve ? win_oh : '0))) | rise;
            if (init_go) isr <= '0;
            else         isr <= (isr & ~eoi_oh) | ((serve && !aeoi_q) ? win_oh : '0);
            if (init_fin)     imr <= '1;
            else if (mask_wr) imr <= bus_wdata[NI-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_out    <= '0;
            vec_valid  <= 1'b0;
            casc_out   <= '0;
            casc_drive <= 1'b0;
        end else if (ack_stb) begin
            vec_valid  <= responding && !(serve && to_slave);
            vec_out    <= {base_q[DW-1:LW], serve ? win : LW'(NI - 1)};
            casc_drive <= serve && to_slave;
            casc_out   <= win;
        end
    end
endmodule

// File: rtl/pic_core_chk.sv
module pic_core_chk
    import pic_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        ack_stb,
    input logic        irq_out,
    input logic        slave_mode,
    input logic        vec_valid,
    input logic [7:0]  vec_out,
    input logic [7:0]  irr,
    input logic [7:0]  isr,
    input logic [7:0]  imr,
    input logic        aeoi_q,
    input init_state_t state
);
    a_r2_mask_set_on_finish: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr && state == ST_GET_MODE) |=> (imr == 8'hFF && state == ST_RUN));

    a_r3_irq_needs_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((irr & ~imr) != 8'h00));

    a_r4_valid_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_valid) |-> $past(ack_stb));

    a_r5_spurious_level7: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_stb && !irq_out && state == ST_RUN && !slave_mode)
        |=> (vec_valid && vec_out[2:0] == 3'd7));

    a_r6_eoi_clears_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !bus_addr && bus_wdata[7:3] == 5'b01100 && state == ST_RUN && !ack_stb)
        |=> !isr[$past(bus_wdata[2:0])]);

    a_r9_auto_eoi_keeps_isr: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && aeoi_q && ack_stb && !bus_wr) |=> $stable(isr));
endmodule

bind pic_core pic_core_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ack_stb(ack_stb), .irq_out(irq_out),
    .slave_mode(slave_mode), .vec_valid(vec_valid), .vec_out(vec_out),
    .irr(irr), .isr(isr), .imr(imr), .aeoi_q(aeoi_q), .state(state)
);

// File: tb/tb_pic_core.sv
`timescale 1ns/1ps
module tb_pic_core;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = 8'h00, bus_rdata;
    logic       slave_mode = 1'b0;
    logic [2:0] casc_in = 3'd0, casc_out;
    logic [7:0] req_in = 8'h00, vec_out;
    logic       irq_out, ack_stb = 1'b0, vec_valid, casc_drive;

    always #2.5 clk = ~clk;

    pic_core dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .slave_mode(slave_mode),
        .casc_in(casc_in), .req_in(req_in), .irq_out(irq_out), .ack_stb(ack_stb),
        .vec_out(vec_out), .vec_valid(vec_valid), .casc_out(casc_out),
        .casc_drive(casc_drive)
    );

    typedef struct {
        int         sel;
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t sbq[$];
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    localparam int SEL_RD = 0, SEL_VEC = 1, SEL_IRQ = 2, SEL_VV = 3, SEL_CASC = 4;

    function automatic logic [7:0] observe(int sel);
        case (sel)
            SEL_RD:   return bus_rdata;
            SEL_VEC:  return vec_out;
            SEL_IRQ:  return {7'b0, irq_out};
            SEL_VV:   return {7'b0, vec_valid};
            default:  return {4'b0, casc_drive, casc_out};
        endcase
    endfunction

    // Monitor: pops expected items and compares them 1 ns after a falling edge.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sbq.size() > 0) begin
                item_t it;
                logic [7:0] act;
                it  = sbq.pop_front();
                act = observe(it.sel);
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic push(int sel, logic [7:0] exp, string tag);
        item_t it;
        it.sel = sel; it.exp = exp; it.tag = tag;
        sbq.push_back(it);
    endtask

    task automatic chk(int sel, logic [7:0] exp, string tag);
        @(negedge clk);
        push(sel, exp, tag);
    endtask

    task automatic rd_chk(logic a, logic [7:0] exp, string tag);
        @(negedge clk);
        bus_addr = a;
        push(SEL_RD, exp, tag);
    endtask

    task automatic wr_reg(logic a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic set_req(logic [7:0] v);
        @(negedge clk);
        req_in = v;
        @(negedge clk);
    endtask

    task automatic do_ack();
        @(negedge clk);
        ack_stb = 1'b1;
        @(negedge clk);
        ack_stb = 1'b0;
    endtask

    task automatic init_seq(logic [7:0] base, logic [7:0] casc, logic [7:0] mode);
        wr_reg(1'b0, 8'h11);
        wr_reg(1'b1, base);
        wr_reg(1'b1, casc);
        wr_reg(1'b1, mode);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        rd_chk(1'b0, 8'h00, "R1 cmd read after reset");
        chk(SEL_IRQ, 8'h00, "R1 irq after reset");
        chk(SEL_VV, 8'h00, "R1 vec_valid after reset");

        // Master: base 0x20, slave on input 2, normal EOI.
        init_seq(8'h20, 8'h04, 8'h01);
        rd_chk(1'b1, 8'hFF, "R2 mask after init");
        rd_chk(1'b0, 8'h00, "R2 request register selected");
        wr_reg(1'b1, 8'h00);
        rd_chk(1'b1, 8'h00, "R8 mask write read back");

        set_req(8'h28);
        rd_chk(1'b0, 8'h28, "R10 edges captured");
        chk(SEL_IRQ, 8'h01, "R3 irq with requests");
        do_ack();
        chk(SEL_VEC, 8'h23, "R4 vector level 3");
        chk(SEL_VV, 8'h01, "R4 vec_valid");
        rd_chk(1'b0, 8'h20, "R4 request bit cleared");
        wr_reg(1'b0, 8'h0B);
        rd_chk(1'b0, 8'h08, "R7 in-service read");
        chk(SEL_IRQ, 8'h00, "R3 lower level blocked by in-service");

        set_req(8'h2A);
        chk(SEL_IRQ, 8'h01, "R3 higher level nests");
        do_ack();
        chk(SEL_VEC, 8'h21, "R4 vector level 1");
        rd_chk(1'b0, 8'h0A, "R4 in-service nested");
        wr_reg(1'b0, 8'h61);
        rd_chk(1'b0, 8'h08, "R6 EOI level 1 only");
        wr_reg(1'b0, 8'h63);
        rd_chk(1'b0, 8'h00, "R7 selection persists after EOI");
        chk(SEL_IRQ, 8'h01, "R3 level 5 presented");

        wr_reg(1'b1, 8'h20);
        chk(SEL_IRQ, 8'h00, "R8 masked input quiet");
        do_ack();
        chk(SEL_VEC, 8'h27, "R5 spurious vector");
        chk(SEL_VV, 8'h01, "R5 spurious valid");
        rd_chk(1'b0, 8'h00, "R5 in-service unchanged");

        wr_reg(1'b1, 8'h00);
        do_ack();
        chk(SEL_VEC, 8'h25, "R4 vector level 5");
        wr_reg(1'b0, 8'h65);
        wr_reg(1'b0, 8'h0A);
        rd_chk(1'b0, 8'h00, "R10 held inputs do not re-request");
        chk(SEL_IRQ, 8'h00, "R10 irq low while held");

        set_req(8'h00);
        set_req(8'h04);
        do_ack();
        chk(SEL_CASC, 8'h0A, "R11 master drives cascade level 2");
        chk(SEL_VV, 8'h00, "R11 master vector withheld");
        wr_reg(1'b0, 8'h0B);
        rd_chk(1'b0, 8'h04, "R11 cascade level in service");
        wr_reg(1'b0, 8'h62);
        rd_chk(1'b0, 8'h00, "R6 EOI level 2");

        // Auto-EOI master, base 0x40.
        init_seq(8'h40, 8'h04, 8'h03);
        rd_chk(1'b1, 8'hFF, "R2 mask after re-init");
        rd_chk(1'b0, 8'h00, "R2 request select after re-init");
        wr_reg(1'b1, 8'h00);
        set_req(8'h00);
        set_req(8'h01);
        do_ack();
        chk(SEL_VEC, 8'h40, "R4 vector level 0 auto");
        wr_reg(1'b0, 8'h0B);
        rd_chk(1'b0, 8'h00, "R9 auto-EOI leaves in-service clear");

        // Slave with identity 2, base 0x70.
        @(negedge clk);
        slave_mode = 1'b1;
        init_seq(8'h70, 8'h02, 8'h01);
        wr_reg(1'b1, 8'h00);
        set_req(8'h00);
        set_req(8'h10);
        @(negedge clk);
        casc_in = 3'd3;
        do_ack();
        chk(SEL_VV, 8'h00, "R11 slave ignores other identity");
        rd_chk(1'b0, 8'h10, "R11 slave request kept");
        @(negedge clk);
        casc_in = 3'd2;
        do_ack();
        chk(SEL_VEC, 8'h74, "R11 slave vector");
        chk(SEL_VV, 8'h01, "R11 slave valid");
        wr_reg(1'b0, 8'h0B);
        rd_chk(1'b0, 8'h10, "R11 slave in-service");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule